// File: doc/BRIEF.md
# Subcode Q Block Capture with CRC Check

This block recovers the Q channel of a subcode stream that arrives as one user bit per audio frame. It looks for a gap of at least 22 consecutive zero bits to find where a block starts. The first one-bit after such a gap is a start marker. The next 96 bits make up the block: 80 Q data bits followed by 16 check bits. The data bits are shifted into a staging register, and all 96 bits go through a serial CRC.

A completed block is only committed once another gap of at least 22 zeros follows it. On that frame the staged data and the CRC result move into the readout register, and an active-low sync pulse starts. The pulse lasts a programmable number of timebase ticks, 136 of 1 µs by default.

A lock error has two effects. It abandons any block in progress. It also clears the CRC-OK flag, but only until the host signals that it has latched the current result. The serial readout logic sits outside this block and drives `host_latch`.

Top module: `subq_capture`

## Requirements
- R1: A user bit is taken only on a cycle with `frame_stb` high. A run of at least SYNC_RUN (22) consecutive zero bits arms the block search. The first one-bit after that run is a start marker, is not stored, and is followed by the 96 block bits.
- R2: The first 80 block bits form the Q data. The earliest received bit lands in `q_data[79]` and the 80th in `q_data[0]`.
- R3: The CRC is 16 bits with polynomial 0x1021 (x^16+x^12+x^5+1) and a preset of zero. It is computed MSB-first over the 80 data bits. Block bits 81 to 96 carry the bitwise inverse of that CRC, most significant bit first. `crc_ok` is 1 after a commit only if they match.
- R4: A commit takes place only on the frame that completes a zero run of SYNC_RUN after all 96 bits have arrived. On that same clock edge `sync_n` falls and `q_data` and `crc_ok` take their new values. Bits received between the end of the block and that run, including one-bits, store nothing.
- R5: `sync_n` stays low for exactly PULSE_TICKS (136) cycles on which `tick_us` is high, counted after the commit. It rises on the edge that registers the last of those ticks.
- R6: If a zero run of SYNC_RUN completes before all 96 bits have arrived, the partial block is dropped. No pulse is issued and `q_data` is unchanged.
- R7: If `locked` is low on any cycle while a block is being collected, that block is dropped with no pulse. A new zero run is then needed before the next block.
- R8: If `locked` is low while `host_latch` has not been pulsed since the last commit, `crc_ok` goes to 0 on the next edge. `q_data` is unchanged.
- R9: After `host_latch` has been pulsed following a commit, a lock error leaves `crc_ok` unchanged.
- R10: After reset, `sync_n` is 1, `crc_ok` is 0 and `q_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-cycle strobe, once per audio frame |
| user_bit | input | 1 | Subcode user bit, valid with `frame_stb` |
| locked | input | 1 | Receiver lock flag; low marks a lock error |
| tick_us | input | 1 | One-cycle timebase tick (1 µs) |
| host_latch | input | 1 | One-cycle pulse when the host latches the result |
| q_data | output | 80 | Readout register with the last committed Q data |
| crc_ok | output | 1 | CRC result of the committed block, subject to lock errors |
| sync_n | output | 1 | Active-low load/sync pulse |

## Verification
Embedded properties check on every cycle that:
- a falling `sync_n` only follows a fully collected block;
- `crc_ok` can only rise while the sync pulse is low;
- any drop of `crc_ok` is explained by either a commit or an unacknowledged lock error;
- a lock error always sends the search back to hunting;
- `sync_n` only rises on a tick.

Only the bench scenarios can show the rest:
- the bit order in `q_data`;
- the CRC verdict on good and corrupted blocks;
- the exact 136-tick width;
- the 21-versus-22 zero boundary;
- the dropping of blocks on early sync or lock loss;
- the role of `host_latch` in protecting the flag.

// File: rtl/subq_pkg.sv
package subq_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_GAP  = 2'd1,
    ST_FILL = 2'd2,
    ST_FULL = 2'd3
  } subq_state_e;
endpackage

// File: rtl/subq_zero_run.sv
module subq_zero_run #(
  parameter int RUN_LEN = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic bit_in,
  input  logic clr,
  output logic hit
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] run_q, run_d, run_inc;

  always_comb begin
    run_inc = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_W'(1);
    run_d   = run_q;
    if (clr)           run_d = '0;
    else if (stb)      run_d = bit_in ? '0 : run_inc;
  end

  // R1: gap is found on the strobe that brings the run to its length
  assign hit = stb && !bit_in && !clr && (run_inc == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  a_r1_one_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && bit_in) |=> (run_q == '0));
endmodule

// File: rtl/subq_crc16.sv
module subq_crc16 #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic shift,
  input  logic bit_in,
  input  logic invert,
  output logic zero
);
  logic [WIDTH-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = (bit_in ^ invert) ^ crc_q[WIDTH-1];
    crc_d = crc_q;
    if (init)       crc_d = '0;
    else if (shift) crc_d = {crc_q[WIDTH-2:0], 1'b0} ^ (fb ? POLY[WIDTH-1:0] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  // R3: continuing the division over the re-inverted check bits leaves zero on a match
  assign zero = (crc_q == '0);

  a_r3_init_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(init && shift));
endmodule

// File: rtl/subq_pulse_timer.sv
module subq_pulse_timer #(
  parameter int TICKS = 136
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic pulse_n
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && tick) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pulse_n = ~active_q;

  a_r5_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_n) |-> $past(tick));
endmodule

// File: rtl/subq_capture.sv
module subq_capture #(
  parameter int          Q_BITS      = 80,
  parameter int          CHK_BITS    = 16,
  parameter int          SYNC_RUN    = 22,
  parameter int          PULSE_TICKS = 136,
  parameter logic [15:0] CRC_POLY    = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              user_bit,
  input  logic              locked,
  input  logic              tick_us,
  input  logic              host_latch,
  output logic [Q_BITS-1:0] q_data,
  output logic              crc_ok,
  output logic              sync_n
);
  import subq_pkg::*;

  localparam int BLK_BITS = Q_BITS + CHK_BITS;
  localparam int CNT_W    = $clog2(BLK_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BLK_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(Q_BITS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  subq_state_e       state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [Q_BITS-1:0] stage_q, q_q;
  logic              ok_q, ok_d, taken_q, taken_d;
  logic              gap_hit, crc_zero;
  logic              crc_init, crc_shift, crc_inv, stage_en, commit;

  subq_zero_run #(.RUN_LEN(SYNC_RUN)) u_run (
    .clk(clk), .rst_n(rst_int), .stb(frame_stb), .bit_in(user_bit),
    .clr(!locked), .hit(gap_hit)
  );

  subq_crc16 #(.WIDTH(CHK_BITS), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_int), .init(crc_init), .shift(crc_shift),
    .bit_in(user_bit), .invert(crc_inv), .zero(crc_zero)
  );

  subq_pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_int), .start(commit), .tick(tick_us), .pulse_n(sync_n)
  );

  always_comb begin
    state_d   = state_q;
    bcnt_d    = bcnt_q;
    crc_init  = 1'b0;
    crc_shift = 1'b0;
    crc_inv   = 1'b0;
    stage_en  = 1'b0;
    commit    = 1'b0;
    if (!locked) begin
      state_d = ST_HUNT;                       // R7
    end else if (frame_stb) begin
      unique case (state_q)
        ST_HUNT: if (gap_hit) state_d = ST_GAP;
        ST_GAP:  if (user_bit) begin           // R1 start marker
          state_d  = ST_FILL;
          bcnt_d   = '0;
          crc_init = 1'b1;
        end
        ST_FILL: begin
          if (gap_hit) begin
            state_d = ST_GAP;                  // R6 early sync restarts
          end else begin
            crc_shift = 1'b1;
            crc_inv   = (bcnt_q >= DATA_END);
            stage_en  = (bcnt_q <  DATA_END);
            if (bcnt_q == LAST_BIT) state_d = ST_FULL;
            else                    bcnt_d  = bcnt_q + CNT_W'(1);
          end
        end
        ST_FULL: if (gap_hit) begin            // R4
          commit  = 1'b1;
          state_d = ST_GAP;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    taken_d = taken_q;
    ok_d    = ok_q;
    if (commit) begin
      taken_d = 1'b0;
      ok_d    = crc_zero;
    end else begin
      if (host_latch)           taken_d = 1'b1;
      if (!locked && !taken_q)  ok_d    = 1'b0;  // R8, R9
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      stage_q <= '0;
      q_q     <= '0;
      ok_q    <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      ok_q    <= ok_d;
      taken_q <= taken_d;
      if (stage_en) stage_q <= {stage_q[Q_BITS-2:0], user_bit};  // R2
      if (commit)   q_q     <= stage_q;
    end
  end

  assign q_data = q_q;
  assign crc_ok = ok_q;

  a_r4_pulse_after_full: assert property (@(posedge clk) disable iff (!rst_int)
    $fell(sync_n) |-> ($past(state_q) == ST_FULL));
  a_r4_ok_rises_in_pulse: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(crc_ok) |-> !sync_n);
  a_r8_ok_drop_cause: assert property (@(posedge clk) disable iff (!rst_int)
    $fell(crc_ok) |-> (($past(!locked) && !$past(taken_q)) || !sync_n));
  a_r7_lock_loss_hunts: assert property (@(posedge clk) disable iff (!rst_int)
    !locked |=> (state_q == ST_HUNT));
endmodule

// File: tb/subq_capture_test.sv
module subq_capture_test;
  localparam int PT = 136;

  logic        clk = 1'b0;
  logic        rst_n, frame_stb, user_bit, locked, tick_us, host_latch;
  logic [79:0] q_data;
  logic        crc_ok, sync_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  subq_capture uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .user_bit(user_bit),
    .locked(locked), .tick_us(tick_us), .host_latch(host_latch),
    .q_data(q_data), .crc_ok(crc_ok), .sync_n(sync_n)
  );

  // {corrupt, payload}
  localparam logic [80:0] VEC [4] = '{
    {1'b0, 80'h0123_4567_89AB_CDEF_0F1F},
    {1'b0, 80'hFFFF_FFFF_FFFF_FFFF_FFFF},
    {1'b1, 80'hA5A5_A5A5_A5A5_A5A5_A5A5},
    {1'b0, 80'h8421_0842_1084_2108_4217}
  };

  function automatic logic [15:0] crc_of(input logic [79:0] d);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic top = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (top) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); frame_stb = 1'b1; user_bit = b;
    @(negedge clk); frame_stb = 1'b0; user_bit = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_payload(input logic [79:0] d, input logic corrupt);
    logic [15:0] chk = ~crc_of(d);
    if (corrupt) chk[0] = ~chk[0];
    send_bit(1'b1);
    for (int i = 79; i >= 0; i--) send_bit(d[i]);
    for (int i = 15; i >= 0; i--) send_bit(chk[i]);
  endtask

  task automatic send_block(input logic [79:0] d, input logic corrupt);
    send_zeros(22);
    send_payload(d, corrupt);
    send_zeros(22);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
    end
  endtask

  task automatic drop_lock();
    @(negedge clk); locked = 1'b0;
    @(negedge clk); locked = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [79:0] last_q;
    rst_n = 1'b0; frame_stb = 1'b0; user_bit = 1'b0; locked = 1'b1;
    tick_us = 1'b0; host_latch = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 sync_n", {79'd0, sync_n}, 80'd1);
    check("R10 crc_ok", {79'd0, crc_ok}, 80'd0);
    check("R10 q_data", q_data, 80'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector walk: R1 R2 R3 R4 R5
    foreach (VEC[k]) begin
      send_block(VEC[k][79:0], VEC[k][80]);
      check("R4 sync low after block", {79'd0, sync_n}, 80'd0);
      check("R2 q_data", q_data, VEC[k][79:0]);
      check("R3 crc_ok", {79'd0, crc_ok}, {79'd0, ~VEC[k][80]});
      if (k == 0) begin
        ticks(PT - 1);
        check("R5 still low before last tick", {79'd0, sync_n}, 80'd0);
        ticks(1);
        check("R5 high after last tick", {79'd0, sync_n}, 80'd1);
      end else begin
        ticks(PT);
      end
    end
    last_q = VEC[3][79:0];

    // R4: 21 zeros after a full block do not commit, the 22nd does
    send_zeros(22);
    send_payload(80'h1357_9BDF_2468_ACE1_3579, 1'b0);
    send_bit(1'b1);
    send_zeros(21);
    check("R4 no commit on 21 zeros", {79'd0, sync_n}, 80'd1);
    check("R4 one-bit after block stores nothing", q_data, last_q);
    send_zeros(1);
    check("R4 commit on 22nd zero", {79'd0, sync_n}, 80'd0);
    check("R4 q_data after commit", q_data, 80'h1357_9BDF_2468_ACE1_3579);
    last_q = 80'h1357_9BDF_2468_ACE1_3579;
    ticks(PT);

    // R6: early sync drops the partial block
    send_zeros(22);
    send_bit(1'b1);
    for (int i = 0; i < 50; i++) send_bit(i[0]);
    send_zeros(22);
    send_zeros(60);
    check("R6 no pulse on early sync", {79'd0, sync_n}, 80'd1);
    check("R6 q_data unchanged", q_data, last_q);

    // R7: lock loss mid-block drops the block
    begin
      logic [79:0] d = 80'hF0F0_F0F0_F0F0_F0F0_F0F1;
      logic [15:0] chk = ~crc_of(d);
      send_zeros(22);
      send_bit(1'b1);
      for (int i = 79; i >= 40; i--) send_bit(d[i]);
      drop_lock();
      for (int i = 39; i >= 0; i--) send_bit(d[i]);
      for (int i = 15; i >= 0; i--) send_bit(chk[i]);
      send_zeros(22);
      check("R7 no pulse after lock loss", {79'd0, sync_n}, 80'd1);
      check("R7 q_data unchanged", q_data, last_q);
    end

    // R8: lock loss before host latch clears the flag
    send_block(80'h0123_4567_89AB_CDEF_0F1F, 1'b0);
    check("R8 flag set after good block", {79'd0, crc_ok}, 80'd1);
    drop_lock();
    check("R8 flag cleared by lock loss", {79'd0, crc_ok}, 80'd0);
    check("R8 q_data kept", q_data, 80'h0123_4567_89AB_CDEF_0F1F);
    ticks(PT);

    // R9: after host latch, lock loss leaves the flag
    send_block(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 1'b0);
    @(negedge clk); host_latch = 1'b1;
    @(negedge clk); host_latch = 1'b0;
    drop_lock();
    check("R9 flag kept after host latch", {79'd0, crc_ok}, 80'd1);
    ticks(PT);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule